// File: doc/BRIEF.md
# UART Transmit Byte Queue with Level Flags

This block sits between a processor write port and a UART transmit shifter. Software writes bytes into a 16-entry queue. The shifter takes the oldest byte through a pop handshake: `pop_valid` shows that a byte is waiting, `pop_data` presents it, and `pop_req` removes it. When the queue is disabled, the same storage works as a single holding register, so only one byte can wait at a time.

The block watches its own fill level and drives three flags.

- The threshold flag is sticky. It rises once the queue has drained to half-empty, which is eight bytes or fewer. The half-empty point is fixed and cannot be programmed.
- The underflow indication shows that the queue has run completely dry.
- The overrun flag is sticky. It records a write that was dropped because storage was full.

The threshold and underflow flags are only active while both the queue enable and the transmit-mode enable are set. Software clears the sticky flags with one strobe. A threshold condition that still holds sets its flag again straight away. Each flag has its own interrupt mask, and the masked flags are combined into one interrupt line.

Top module: `uart_txq`

## Requirements
- R1: After reset, `level` is 0 and `pop_valid`, `thr_flag`, `undr_flag`, `ovr_flag` and `irq` are all low.
- R2: With `fifo_en` high, the queue holds up to 16 bytes and hands them out in write order. While `level` is nonzero, `pop_valid` is high and `pop_data` shows the oldest byte. A `pop_req` removes that byte at the clock edge.
- R3: A write (`wr_valid`) accepted at an edge raises `level` by one. A write that arrives while `level` equals the capacity is dropped and leaves the stored bytes unchanged. A dropped write sets `ovr_flag` at that edge, and the flag stays high until a `sw_clr` edge with no new dropped write.
- R4: A `pop_req` while `level` is 0 changes nothing: `level` stays 0 and `pop_valid` stays low.
- R5: With `fifo_en` low, the capacity is one byte, so a second write before a pop is dropped.
- R6: At every clock edge where `fifo_en` and `tx_en` are both high and `level` is 8 or less, `thr_flag` is set. This includes the first edge after both enables become high.
- R7: `thr_flag` holds its value until a `sw_clr` edge. If the R6 condition holds at the same edge as the clear, the flag stays set.
- R8: `undr_flag` is high exactly while `fifo_en` and `tx_en` are both high and `level` is 0, with no clock delay.
- R9: `irq` equals (`thr_flag` AND `mask_thr`) OR (`undr_flag` AND `mask_undr`) OR (`ovr_flag` AND `mask_ovr`), with no clock delay.
- R10: `level` reports the number of stored bytes, from 0 to 16. A push and a pop at the same edge leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 16-entry queue; 0: single holding register |
| tx_en | input | 1 | Transmit mode enable; arms threshold and underflow |
| wr_valid | input | 1 | Write strobe from the processor |
| wr_data | input | 8 | Byte to write |
| pop_req | input | 1 | Shifter takes the oldest byte |
| sw_clr | input | 1 | Software clear of the threshold and overrun flags |
| mask_thr | input | 1 | Interrupt enable for the threshold flag |
| mask_undr | input | 1 | Interrupt enable for underflow |
| mask_ovr | input | 1 | Interrupt enable for overrun |
| pop_valid | output | 1 | A byte is available |
| pop_data | output | 8 | Oldest stored byte |
| level | output | 5 | Number of stored bytes |
| thr_flag | output | 1 | Sticky half-empty flag |
| undr_flag | output | 1 | Queue empty while armed |
| ovr_flag | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Masked OR of the flags |

## Verification
Writes, pops and drops show on `level`, `pop_valid` and `pop_data` in the first cycle after the edge that takes them. `thr_flag` and `ovr_flag` also change at that same edge. `undr_flag` and `irq` follow the settled state within the same cycle. The bench drives all inputs on the falling edge. At each rising edge it advances its own reference queue and flag model, using the values that were present before the edge. It then compares every output at the following falling edge, so each result is checked exactly in the cycle it is due.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
   typedef enum logic {
      MODE_HOLD = 1'b0,
      MODE_QUEUE = 1'b1
   } txq_mode_e;

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/uart_txq_store.sv
module uart_txq_store
   import uart_txq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  txq_mode_e         mode,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  level,
   output logic              wr_drop
);
   logic [DATA_W-1:0] slot [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  cap;
   logic              push, pop;

   assign cap     = (mode == MODE_QUEUE) ? CNT_W'(DEPTH) : CNT_W'(1);
   assign push    = wr_valid && (level < cap);
   assign pop     = pop_req && (level != '0);
   assign wr_drop = wr_valid && (level >= cap);
   assign rd_data = slot[rd_ptr];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot[g] <= '0;
         else if (push && (wr_ptr == PTR_W'(g)))
            slot[g] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_drop && !pop_req) |=> (level == $past(level)));                // R3
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !wr_valid && level == '0) |=> (level == '0));          // R4
   AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));                                           // R10
endmodule

// File: rtl/uart_txq_flags.sv
module uart_txq_flags
   import uart_txq_pkg::*;
#(
   parameter int CNT_W = 5,
   parameter int THRESH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  txq_mode_e        mode,
   input  logic             tx_en,
   input  logic [CNT_W-1:0] level,
   input  logic             wr_drop,
   input  logic             sw_clr,
   input  logic             mask_thr,
   input  logic             mask_undr,
   input  logic             mask_ovr,
   output logic             thr_flag,
   output logic             undr_flag,
   output logic             ovr_flag,
   output logic             irq
);
   logic armed, thr_hit;

   assign armed     = (mode == MODE_QUEUE) && tx_en;
   assign thr_hit   = armed && (level <= CNT_W'(THRESH));
   assign undr_flag = armed && (level == '0);
   assign irq       = (thr_flag & mask_thr) | (undr_flag & mask_undr) | (ovr_flag & mask_ovr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_flag <= 1'b0;
         ovr_flag <= 1'b0;
      end else begin
         thr_flag <= thr_hit | (thr_flag & ~sw_clr);
         ovr_flag <= wr_drop | (ovr_flag & ~sw_clr);
      end
   end

   AST_THR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      thr_hit |=> thr_flag);                                             // R6
   AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_flag && !sw_clr) |=> thr_flag);                               // R7
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drop |=> ovr_flag);                                             // R3
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_thr && !mask_undr && !mask_ovr) |-> !irq);                  // R9
endmodule

// File: rtl/uart_txq.sv
module uart_txq
   import uart_txq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int THRESH = DEPTH / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              tx_en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop_req,
   input  logic              sw_clr,
   input  logic              mask_thr,
   input  logic              mask_undr,
   input  logic              mask_ovr,
   output logic              pop_valid,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  level,
   output logic              thr_flag,
   output logic              undr_flag,
   output logic              ovr_flag,
   output logic              irq
);
   if (!is_pow2(DEPTH)) begin : g_bad_depth
      $error("uart_txq: DEPTH must be a power of two and at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("uart_txq: DATA_W must be positive");
   end

   txq_mode_e mode;
   logic      wr_drop;

   assign mode      = fifo_en ? MODE_QUEUE : MODE_HOLD;
   assign pop_valid = (level != '0);

   uart_txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .wr_valid(wr_valid), .wr_data(wr_data), .pop_req(pop_req),
      .rd_data(pop_data), .level(level), .wr_drop(wr_drop)
   );

   uart_txq_flags #(.CNT_W(CNT_W), .THRESH(THRESH)) u_flags (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tx_en(tx_en),
      .level(level), .wr_drop(wr_drop), .sw_clr(sw_clr),
      .mask_thr(mask_thr), .mask_undr(mask_undr), .mask_ovr(mask_ovr),
      .thr_flag(thr_flag), .undr_flag(undr_flag), .ovr_flag(ovr_flag), .irq(irq)
   );

   AST_VALID_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_valid && !pop_req && !wr_drop) |=> pop_valid);                // R2
endmodule

// File: tb/uart_txq_test.sv
module uart_txq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 0, tx_en = 0, wr_valid = 0, pop_req = 0, sw_clr = 0;
   logic       mask_thr = 0, mask_undr = 0, mask_ovr = 0;
   logic [7:0] wr_data = 0;
   logic       pop_valid, thr_flag, undr_flag, ovr_flag, irq;
   logic [7:0] pop_data;
   logic [4:0] level;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [7:0] mq[$];
   bit m_thr = 0, m_ovr = 0;

   always #10 clk = ~clk;

   uart_txq uut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_en(tx_en),
      .wr_valid(wr_valid), .wr_data(wr_data), .pop_req(pop_req), .sw_clr(sw_clr),
      .mask_thr(mask_thr), .mask_undr(mask_undr), .mask_ovr(mask_ovr),
      .pop_valid(pop_valid), .pop_data(pop_data), .level(level),
      .thr_flag(thr_flag), .undr_flag(undr_flag), .ovr_flag(ovr_flag), .irq(irq)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_undr();
      return fifo_en && tx_en && (mq.size() == 0);
   endfunction

   function automatic bit exp_irq();
      return (m_thr & mask_thr) | (exp_undr() & mask_undr) | (m_ovr & mask_ovr);
   endfunction

   // inputs are set before this call (at a falling edge); advance one cycle and compare
   task automatic step();
      int cap = fifo_en ? 16 : 1;
      int lvl;
      bit drop, hit;
      @(posedge clk);
      lvl  = mq.size();
      drop = wr_valid && (lvl >= cap);
      hit  = fifo_en && tx_en && (lvl <= 8);
      if (pop_req && lvl > 0) void'(mq.pop_front());
      if (wr_valid && lvl < cap) mq.push_back(wr_data);
      m_thr = hit | (m_thr & ~sw_clr);
      m_ovr = drop | (m_ovr & ~sw_clr);
      @(negedge clk);
      chk("R10", level, mq.size());
      chk("R2", pop_valid, mq.size() != 0);
      if (mq.size() != 0) chk("R2", pop_data, mq[0]);
      chk("R3", ovr_flag, m_ovr);
      chk("R7", thr_flag, m_thr);
      chk("R8", undr_flag, exp_undr());
      chk("R9", irq, exp_irq());
   endtask

   task automatic drive(bit w, logic [7:0] d, bit p, bit c);
      wr_valid = w; wr_data = d; pop_req = p; sw_clr = c;
      step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", level, 0);
      chk("R1", pop_valid, 0);
      chk("R1", thr_flag | undr_flag | ovr_flag | irq, 0);

      // R6: arming with an empty queue sets the threshold at the next edge
      fifo_en = 1; tx_en = 1; mask_thr = 1; mask_undr = 1; mask_ovr = 1;
      drive(0, 0, 0, 0);
      chk("R6", thr_flag, 1);
      chk("R8", undr_flag, 1);

      // R4: pop on empty
      drive(0, 0, 1, 0);
      chk("R4", level, 0);
      chk("R4", pop_valid, 0);

      // R7: clear while the level condition holds, hardware set wins
      drive(0, 0, 0, 1);
      chk("R7", thr_flag, 1);

      // fill to 16, then one more write that must be dropped
      for (int i = 0; i < 16; i++) drive(1, 8'(8'h40 + i), 0, 0);
      chk("R2", level, 16);
      drive(0, 0, 0, 1);
      chk("R7", thr_flag, 0);
      drive(1, 8'hEE, 0, 0);
      chk("R3", ovr_flag, 1);
      chk("R3", pop_data, 8'h40);
      chk("R3", level, 16);

      // drain to eight bytes: the threshold comes back
      for (int i = 0; i < 8; i++) drive(0, 0, 1, 0);
      drive(0, 0, 0, 0);
      chk("R6", thr_flag, 1);
      drive(1, 8'h11, 1, 1);
      chk("R10", level, 8);

      // R5: holding-register mode takes one byte only
      while (mq.size() != 0) drive(0, 0, 1, 0);
      fifo_en = 0;
      drive(0, 0, 0, 1);
      drive(1, 8'hA5, 0, 0);
      drive(1, 8'h5A, 0, 0);
      chk("R5", level, 1);
      chk("R5", pop_data, 8'hA5);
      chk("R5", ovr_flag, 1);
      drive(0, 0, 1, 1);

      // constrained random traffic
      void'($urandom(32'd2024));
      for (int i = 0; i < 4000; i++) begin
         int wr_pct = (i / 500) % 2 ? 30 : 70;
         if ($urandom_range(0, 99) < 2) fifo_en = ~fifo_en;
         if ($urandom_range(0, 99) < 2) tx_en = ~tx_en;
         if ($urandom_range(0, 99) < 3) begin
            mask_thr = 1'($urandom); mask_undr = 1'($urandom); mask_ovr = 1'($urandom);
         end
         drive($urandom_range(0, 99) < wr_pct, 8'($urandom),
               $urandom_range(0, 99) < 100 - wr_pct, $urandom_range(0, 99) < 8);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule